// File: doc/BRIEF.md
# ARINC 429 Word Transmitter with Byte Host Port

This block turns 32-bit ARINC 429 words into a return-to-zero, two-rail serial stream. The block's clock runs at four times the bit rate. A host loads each word through an 8-bit port in one of two ways. In buffered mode the host writes all four bytes before transmission. In streaming mode the host writes one byte at a time while the word is already on the line. A control register selects the mode, whether bit 32 carries odd parity or host data, a self-test loopback and a transmit enable.

A word starts in one of two ways. Either the active-low gate input is low while the enable bit is set, or a control write takes the enable bit from 0 to 1. In both cases a complete word (buffered mode) or a first byte (streaming mode) must already be loaded. The host watches a ready flag to pace its writes and an idle flag that is low for the whole word. In streaming mode, a host that falls behind the serialiser gets an underwrite error. The error halts the transmitter until the host reads the status register.

Top module: `a429_word_tx`

## Requirements
- R1: While a bit is driven, the one rail (`line_one`) is high for a 1 and the zero rail (`line_zero`) is high for a 0. The two rails are never high together, and both are low whenever `tx_idle` is high.
- R2: Each bit takes four clock cycles. The bit's rail is high for the first two cycles and both rails are low for the last two.
- R3: Bit 1 is sent first and bit 32 last. The first byte written is bits 1 to 8, least significant bit first, followed by the second, third and fourth bytes in write order.
- R4: Control bit 5 selects what bit 32 carries. When it is 1, bit 32 is the odd parity of bits 1 to 31, so the word holds an odd number of ones. When it is 0, bit 32 is bit 7 of the fourth byte.
- R5: A word starts in either of two cases, provided data is available and no error is pending. The first case is `gate_n` low while control bit 0 (enable) is 1. The second is a control write that changes bit 0 from 0 to 1. While `gate_n` stays high and enable stays constant, a loaded word waits.
- R6: `tx_idle` is low from the first bit until at least four null bit-times have followed bit 32. The rails stay null for at least 16 cycles between consecutive words.
- R7: In buffered mode (control bit 6 = 1), `tx_ready` stays high while fewer than four bytes are held and the transmitter is idle. It drops after the fourth data write, and the word is sent only once four bytes are held.
- R8: In streaming mode (control bit 6 = 0), `tx_ready` is low in the cycle after a data write. It rises again once the serialiser takes the byte. A data write made while `tx_ready` is low is dropped.
- R9: In streaming mode, if the next byte has not been written by the end of the current byte's 8th bit, the word is abandoned. The rails then go null, and both `tx_err` and status bit 7 are set.
- R10: While an error is pending, no word starts, even with data loaded and the gate open. A status read (`rd_en` with `sel_ctrl` = 1) clears the error. Status bit 0 is ready, bit 2 is idle and bit 7 is the error; the other bits read 0.
- R11: With control bit 4 (self-test) set, `line_one` and `line_zero` stay low and the stream appears on `loop_one` and `loop_zero`. With it clear, the loop outputs stay low.
- R12: After reset the control register is 0x21: enable on, parity on, streaming mode, self-test off. `tx_ready` and `tx_idle` are high, `tx_err` is low and the status reads 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, four times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| sel_ctrl | input | 1 | 1 selects control write / status read, 0 selects data |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; with `sel_ctrl` it clears the error |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Status byte when `sel_ctrl` is 1, else zero |
| gate_n | input | 1 | Active-low hardware transmit gate |
| line_one | output | 1 | Ones rail to the line driver |
| line_zero | output | 1 | Zeros rail to the line driver |
| loop_one | output | 1 | Ones rail of the self-test loopback |
| loop_zero | output | 1 | Zeros rail of the self-test loopback |
| tx_ready | output | 1 | Host may write the next data byte |
| tx_idle | output | 1 | Low while a word and its gap are in progress |
| tx_err | output | 1 | Underwrite error pending |

## Verification
The bench goes after four corner cases.

- Streaming underwrite: the host starves the serialiser after one byte. A design that misses the deadline keeps sending a stale byte instead of stopping after exactly eight bits.
- Error lock: a byte is loaded while the error is pending, with the gate open. A design whose halt leaks starts the word before the status read.
- Write collision: a second data write lands while `tx_ready` is low. A design that accepts it sends the wrong first byte.
- Parity: bit 32 is checked with parity on and off, using a word whose data bit differs from its parity bit. A mis-seeded or mis-inverted accumulator shows up as a flipped last pulse.

The bench also checks the return-to-zero pulse shape and the inter-word gap. Finally, it confirms that the buffered and enable-edge starts hold a loaded word until their trigger arrives.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

  // control register bit positions
  localparam int CB_EN       = 0;
  localparam int CB_SELFTEST = 4;
  localparam int CB_PARITY   = 5;
  localparam int CB_BUFMODE  = 6;
  localparam logic [7:0] CTRL_RESET = 8'h21;

  // status register bit positions
  localparam int SB_READY = 0;
  localparam int SB_IDLE  = 2;
  localparam int SB_ERR   = 7;

  typedef enum logic [1:0] {SER_IDLE, SER_SEND, SER_GAP} ser_state_e;

  function automatic logic [7:0] pack_status(input logic ready, input logic idle,
                                             input logic err);
    logic [7:0] s;
    s = 8'h00;
    s[SB_READY] = ready;
    s[SB_IDLE]  = idle;
    s[SB_ERR]   = err;
    return s;
  endfunction

  // value on the line for the current bit: generated odd parity on the
  // final bit when enabled, otherwise the shifted data bit
  function automatic logic line_bit(input logic par_en, input logic final_bit,
                                    input logic ones_acc, input logic data);
    return (par_en && final_bit) ? ~ones_acc : data;
  endfunction

endpackage

// File: rtl/a429_tx_regs.sv
module a429_tx_regs
  import a429_tx_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int IDX_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_ctrl,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wr_data,
  input  logic             busy,
  input  logic             take,
  input  logic             word_done,
  input  logic             underrun,
  input  logic [IDX_W-1:0] fetch_idx,
  output logic [7:0]       rd_data,
  output logic             tx_ready,
  output logic             tx_err,
  output logic             en,
  output logic             en_rise,
  output logic             self_test,
  output logic             par_en,
  output logic             buf_mode,
  output logic             have_data,
  output logic             have_next,
  output logic [7:0]       fetch_byte
);
  localparam int CNT_W = $clog2(WORD_BYTES + 1);

  logic [7:0]       store [WORD_BYTES];
  logic [CNT_W-1:0] cnt;
  logic             en_prev;
  logic             data_wr, ctrl_wr, stat_rd;
  logic [IDX_W-1:0] wr_idx;

  assign data_wr = wr_en && !sel_ctrl && tx_ready;
  assign ctrl_wr = wr_en && sel_ctrl;
  assign stat_rd = rd_en && sel_ctrl;
  assign wr_idx  = buf_mode ? cnt[IDX_W-1:0] : '0;

  always_comb begin
    if (buf_mode) begin
      tx_ready  = (cnt < CNT_W'(WORD_BYTES)) && !busy;
      have_data = (cnt == CNT_W'(WORD_BYTES));
      have_next = 1'b1;
    end else begin
      tx_ready  = (cnt == '0);
      have_data = (cnt != '0);
      have_next = (cnt != '0);
    end
  end

  assign fetch_byte = buf_mode ? store[fetch_idx] : store[0];
  assign en_rise    = en && !en_prev;
  assign rd_data    = sel_ctrl ? pack_status(tx_ready, !busy, tx_err) : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= CTRL_RESET[CB_EN];
      self_test <= CTRL_RESET[CB_SELFTEST];
      par_en    <= CTRL_RESET[CB_PARITY];
      buf_mode  <= CTRL_RESET[CB_BUFMODE];
      en_prev   <= CTRL_RESET[CB_EN];
    end else begin
      en_prev <= en;
      if (ctrl_wr) begin
        en        <= wr_data[CB_EN];
        self_test <= wr_data[CB_SELFTEST];
        par_en    <= wr_data[CB_PARITY];
        buf_mode  <= wr_data[CB_BUFMODE];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (buf_mode) begin
      if (word_done)    cnt <= '0;
      else if (data_wr) cnt <= cnt + CNT_W'(1);
    end else begin
      if (take)         cnt <= '0;
      else if (data_wr) cnt <= CNT_W'(1);
    end
  end

  generate
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_store
      always_ff @(posedge clk) begin
        if (rst)                                      store[g] <= 8'h00;
        else if (data_wr && wr_idx == IDX_W'(g))      store[g] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           tx_err <= 1'b0;
    else if (underrun) tx_err <= 1'b1;
    else if (stat_rd)  tx_err <= 1'b0;
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !buf_mode) |=> !tx_ready); // R8
  AST_UNDERRUN_FLAGS: assert property (@(posedge clk) disable iff (rst)
    underrun |=> tx_err); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tx_err && !stat_rd) |=> tx_err); // R10

endmodule

// File: rtl/a429_tx_ser.sv
module a429_tx_ser
  import a429_tx_pkg::*;
#(
  parameter int CLK_PER_BIT = 4,
  parameter int GAP_BITS    = 4,
  parameter int WORD_BYTES  = 4,
  parameter int IDX_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err,
  input  logic             en,
  input  logic             en_rise,
  input  logic             gate_n,
  input  logic             par_en,
  input  logic             have_data,
  input  logic             have_next,
  input  logic [7:0]       fetch_byte,
  output logic             busy,
  output logic             take,
  output logic             word_done,
  output logic             underrun,
  output logic [IDX_W-1:0] fetch_idx,
  output logic             rz_one,
  output logic             rz_zero
);
  localparam int PH_W    = $clog2(CLK_PER_BIT);
  localparam int HI_PH   = CLK_PER_BIT / 2;
  localparam int GAP_CYC = GAP_BITS * CLK_PER_BIT;
  localparam int GC_W    = $clog2(GAP_CYC + 1);

  ser_state_e       st;
  logic [PH_W-1:0]  phase;
  logic [2:0]       bit_idx;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0]       sh;
  logic             acc;
  logic [GC_W-1:0]  gcnt;

  logic start, bit_end, byte_end, last_byte, cur_bit, rail;

  assign start     = (st == SER_IDLE) && !err && en && have_data && (!gate_n || en_rise);
  assign bit_end   = (st == SER_SEND) && (phase == PH_W'(CLK_PER_BIT - 1));
  assign byte_end  = bit_end && (bit_idx == 3'd7);
  assign last_byte = (byte_idx == IDX_W'(WORD_BYTES - 1));
  assign word_done = byte_end && last_byte;
  assign underrun  = byte_end && !last_byte && !have_next;
  assign take      = start || (byte_end && !last_byte && have_next);
  assign fetch_idx = start ? '0 : byte_idx + IDX_W'(1);
  assign busy      = (st != SER_IDLE);

  assign cur_bit = line_bit(par_en, last_byte && (bit_idx == 3'd7), acc, sh[0]);
  assign rail    = (st == SER_SEND) && (phase < PH_W'(HI_PH));
  assign rz_one  = rail && cur_bit;
  assign rz_zero = rail && !cur_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SER_IDLE;
      phase    <= '0;
      bit_idx  <= '0;
      byte_idx <= '0;
      sh       <= '0;
      acc      <= 1'b0;
      gcnt     <= '0;
    end else begin
      case (st)
        SER_IDLE: if (start) begin
          st       <= SER_SEND;
          sh       <= fetch_byte;
          phase    <= '0;
          bit_idx  <= '0;
          byte_idx <= '0;
          acc      <= 1'b0;
        end
        SER_SEND: begin
          phase <= phase + PH_W'(1);
          if (bit_end) begin
            acc     <= acc ^ cur_bit;
            sh      <= sh >> 1;
            bit_idx <= bit_idx + 3'd1;
            if (word_done) begin
              st   <= SER_GAP;
              gcnt <= '0;
            end else if (underrun) begin
              st <= SER_IDLE;
            end else if (byte_end) begin
              sh       <= fetch_byte;
              byte_idx <= byte_idx + IDX_W'(1);
            end
          end
        end
        SER_GAP: begin
          gcnt <= gcnt + GC_W'(1);
          if (gcnt == GC_W'(GAP_CYC - 1)) st <= SER_IDLE;
        end
        default: st <= SER_IDLE;
      endcase
    end
  end

  AST_RZ_TWO_PHASES: assert property (@(posedge clk) disable iff (rst)
    $rose(rz_one || rz_zero) |=> (rz_one || rz_zero)); // R2
  AST_GAP_BEFORE_NEXT: assert property (@(posedge clk) disable iff (rst)
    $past(st == SER_GAP) |-> (st != SER_SEND)); // R6
  AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
    (err && st == SER_IDLE) |=> (st == SER_IDLE)); // R10

endmodule

// File: rtl/a429_tx_line.sv
module a429_tx_line (
  input  logic rz_one,
  input  logic rz_zero,
  input  logic self_test,
  output logic line_one,
  output logic line_zero,
  output logic loop_one,
  output logic loop_zero
);
  assign line_one  = rz_one  && !self_test;
  assign line_zero = rz_zero && !self_test;
  assign loop_one  = rz_one  &&  self_test;
  assign loop_zero = rz_zero &&  self_test;
endmodule

// File: rtl/a429_word_tx.sv
module a429_word_tx #(
  parameter int CLK_PER_BIT = 4,
  parameter int GAP_BITS    = 4,
  parameter int WORD_BYTES  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_ctrl,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       gate_n,
  output logic       line_one,
  output logic       line_zero,
  output logic       loop_one,
  output logic       loop_zero,
  output logic       tx_ready,
  output logic       tx_idle,
  output logic       tx_err
);
  localparam int IDX_W = $clog2(WORD_BYTES);

  logic             busy, take, word_done, underrun;
  logic [IDX_W-1:0] fetch_idx;
  logic             en, en_rise, self_test, par_en, buf_mode;
  logic             have_data, have_next;
  logic [7:0]       fetch_byte;
  logic             rz_one, rz_zero;

  a429_tx_regs #(.WORD_BYTES(WORD_BYTES), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .sel_ctrl(sel_ctrl), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .busy(busy), .take(take), .word_done(word_done),
    .underrun(underrun), .fetch_idx(fetch_idx), .rd_data(rd_data),
    .tx_ready(tx_ready), .tx_err(tx_err), .en(en), .en_rise(en_rise),
    .self_test(self_test), .par_en(par_en), .buf_mode(buf_mode),
    .have_data(have_data), .have_next(have_next), .fetch_byte(fetch_byte)
  );

  a429_tx_ser #(.CLK_PER_BIT(CLK_PER_BIT), .GAP_BITS(GAP_BITS),
                .WORD_BYTES(WORD_BYTES), .IDX_W(IDX_W)) u_ser (
    .clk(clk), .rst(rst), .err(tx_err), .en(en), .en_rise(en_rise),
    .gate_n(gate_n), .par_en(par_en), .have_data(have_data),
    .have_next(have_next), .fetch_byte(fetch_byte), .busy(busy), .take(take),
    .word_done(word_done), .underrun(underrun), .fetch_idx(fetch_idx),
    .rz_one(rz_one), .rz_zero(rz_zero)
  );

  a429_tx_line u_line (
    .rz_one(rz_one), .rz_zero(rz_zero), .self_test(self_test),
    .line_one(line_one), .line_zero(line_zero),
    .loop_one(loop_one), .loop_zero(loop_zero)
  );

  assign tx_idle = !busy;

  AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(line_one && line_zero) && !(loop_one && loop_zero)); // R1
  AST_IDLE_IS_NULL: assert property (@(posedge clk) disable iff (rst)
    tx_idle |-> (!line_one && !line_zero)); // R1
  AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !self_test |-> (!loop_one && !loop_zero)); // R11

endmodule

// File: tb/a429_word_tx_bench.sv
module a429_word_tx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_ctrl = 1'b0, wr_en = 1'b0, rd_en = 1'b0, gate_n = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       line_one, line_zero, loop_one, loop_zero;
  logic       tx_ready, tx_idle, tx_err;

  always #5 clk = ~clk;

  a429_word_tx u_a429_word_tx (
    .clk(clk), .rst(rst), .sel_ctrl(sel_ctrl), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .gate_n(gate_n),
    .line_one(line_one), .line_zero(line_zero), .loop_one(loop_one),
    .loop_zero(loop_zero), .tx_ready(tx_ready), .tx_idle(tx_idle), .tx_err(tx_err)
  );

  int  n_tests = 0, n_fail = 0;
  bit  exp_q[$];
  bit  mon_loop = 0, mon_first = 1, stray = 0, both_hi = 0, prev_act = 0, done = 0;
  int  mon_bit = 0, pulses = 0, high_run = 0, null_run = 100;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: each rail pulse pops one expected bit
  always @(negedge clk) begin
    if (!rst) begin
      bit r1, r0, act, e;
      r1  = mon_loop ? loop_one  : line_one;
      r0  = mon_loop ? loop_zero : line_zero;
      act = r1 | r0;
      if (mon_loop ? (line_one | line_zero) : (loop_one | loop_zero)) stray = 1;
      if (r1 && r0) both_hi = 1;
      if (act && !prev_act) begin
        pulses++;
        if (exp_q.size() == 0) chk(0, "R3 unexpected pulse", r1, 0);
        else begin
          e = exp_q.pop_front();
          chk(r1 == e, (mon_bit == 31) ? "R4 bit32" : "R3 bit value", r1, e);
        end
        if (tx_idle) chk(0, "R6 idle high during bit", 1, 0);
        if (mon_bit != 0 && null_run != 2) chk(0, "R2 low phase", null_run, 2);
        if (mon_bit == 0 && !mon_first && null_run < 16) chk(0, "R6 gap", null_run, 16);
        mon_bit   = (mon_bit + 1) % 32;
        mon_first = 0;
        high_run  = 1;
      end else if (act) high_run++;
      else if (prev_act) begin
        chk(high_run == 2, "R2 high phase", high_run, 2);
        null_run = 1;
      end else null_run++;
      prev_act = act;
    end
  end

  task automatic push_bits(input logic [31:0] w, input int n, input bit par);
    for (int i = 0; i < n; i++)
      exp_q.push_back((i == 31 && par) ? ~^w[30:0] : w[i]);
  endtask

  task automatic wr(input bit ctrl, input logic [7:0] d);
    @(posedge clk); #1; sel_ctrl = ctrl; wr_en = 1; wr_data = d;
    @(posedge clk); #1; wr_en = 0; sel_ctrl = 0;
  endtask

  task automatic rd_status(output logic [7:0] v);
    @(posedge clk); #1; sel_ctrl = 1; rd_en = 1; #1; v = rd_data;
    @(posedge clk); #1; rd_en = 0; sel_ctrl = 0;
  endtask

  task automatic stream(input logic [31:0] w, input int from);
    for (int k = from; k < 4; k++) begin
      while (!tx_ready) @(posedge clk);
      #1; wr(0, w[8*k +: 8]);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      if (exp_q.size() == 0 && tx_idle) break;
    end
    chk(exp_q.size() == 0, "R3 all bits sent", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    int p0;
    repeat (3) @(posedge clk); #1; rst = 0;
    @(negedge clk);
    // R12 reset state
    chk(tx_ready && tx_idle && !tx_err, "R12 reset flags", {tx_ready, tx_idle, tx_err}, 3'b110);
    chk(!line_one && !line_zero, "R1 null after reset", {line_one, line_zero}, 0);
    rd_status(s); chk(s == 8'h05, "R12 reset status", s, 8'h05);

    // R12/R5/R4: default control streams words with parity once gate is low
    gate_n = 0;
    push_bits(32'h8C3A5E17, 32, 1); stream(32'h8C3A5E17, 0);
    push_bits(32'h01020304, 32, 1); stream(32'h01020304, 0);   // R6 gap
    wait_idle();

    // R8 dropped write + R5 gate hold
    gate_n = 1;
    wr(0, 8'h11); chk(!tx_ready, "R8 ready low after write", tx_ready, 0);
    wr(0, 8'h22);
    rd_status(s); chk(s == 8'h04, "R8 status ready low", s, 8'h04);
    p0 = pulses; repeat (30) @(posedge clk);
    chk(pulses == p0, "R5 waits for gate", pulses - p0, 0);
    push_bits(32'hC3B2A111, 32, 1);
    gate_n = 0; stream(32'hC3B2A111, 1); wait_idle();

    // R9 underwrite
    push_bits(32'h000000A5, 8, 1);
    wr(0, 8'hA5); repeat (60) @(posedge clk); #1;
    chk(tx_err, "R9 error pin", tx_err, 1);
    chk(exp_q.size() == 0, "R9 only first byte sent", exp_q.size(), 0);
    chk(tx_idle, "R9 word abandoned", tx_idle, 1);
    // R10 halt while error, then clear
    mon_bit = 0; mon_first = 1;
    push_bits(32'h5A6B7C8D, 32, 1);
    wr(0, 8'h8D); p0 = pulses; repeat (100) @(posedge clk);
    chk(pulses == p0, "R10 no start during error", pulses - p0, 0);
    rd_status(s); chk(s == 8'h84, "R10 status with error", s, 8'h84);
    #1; chk(!tx_err, "R10 cleared by read", tx_err, 0);
    stream(32'h5A6B7C8D, 1); wait_idle();

    // R7 buffered mode
    gate_n = 1; wr(1, 8'h61);
    push_bits(32'hF00DBEEF, 32, 1);
    wr(0, 8'hEF); wr(0, 8'hBE); wr(0, 8'h0D);
    chk(tx_ready, "R7 ready with three bytes", tx_ready, 1);
    wr(0, 8'hF0);
    chk(!tx_ready, "R7 ready low when full", tx_ready, 0);
    p0 = pulses; repeat (20) @(posedge clk);
    chk(pulses == p0, "R5 buffered waits for gate", pulses - p0, 0);
    gate_n = 0; wait_idle();

    // R4 parity off: bit 32 is data
    wr(1, 8'h41);
    push_bits(32'h70000001, 32, 0);
    wr(0, 8'h01); wr(0, 8'h00); wr(0, 8'h00); wr(0, 8'h70); wait_idle();

    // R5 enable rising edge start
    gate_n = 1; wr(1, 8'h60);
    push_bits(32'h12345678, 32, 1);
    wr(0, 8'h78); wr(0, 8'h56); wr(0, 8'h34); wr(0, 8'h12);
    p0 = pulses; repeat (40) @(posedge clk);
    chk(pulses == p0, "R5 disabled holds word", pulses - p0, 0);
    wr(1, 8'h61); wait_idle();

    // R11 self-test loopback
    wr(1, 8'h31); mon_loop = 1; gate_n = 0;
    push_bits(32'hA5C30F96, 32, 1); stream(32'hA5C30F96, 0); wait_idle();
    repeat (4) @(posedge clk);
    mon_loop = 0; wr(1, 8'h21);
    chk(!stray, "R11 inactive outputs stayed null", stray, 0);
    chk(!both_hi, "R1 rails exclusive", both_hi, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule